// File: doc/BRIEF.md
# Card Host Data Transfer Controller

This block sits on the data path of a memory-card host, between the system bus and the card-side data engine. A word FIFO buffers the traffic in both directions. On a write toward the card, the system fills the FIFO and the card engine drains it. On a read from the card, the card engine fills the FIFO and the system drains it. The direction is latched when a new transfer command starts, and that start also flushes the FIFO.

The block decides when a write may begin. The start threshold depends on the block length measured against the FIFO depth, unless an immediate-start bit forces the write to begin with the first word. The block raises sticky flags when the card engine overruns or starves the FIFO, and a mode bit selects how those flags are cleared. It counts block-end strobes and, when a command is waiting, decides which block boundary gets a one-cycle issue pulse. A high-speed bit selects the card clock edge on which the card-side outputs launch.

Top module: `sdhost_xfer_ctl`

## Requirements
- R1: With `cfg_start_now`=1, `wr_go` is 1 as soon as the FIFO holds at least one word during a write transfer.
- R2: With `cfg_start_now`=0 and ceil(`blk_len_bytes`/4) >= 3/4 of DEPTH, `wr_go` rises when the FIFO level reaches DEPTH/2.
- R3: With `cfg_start_now`=0 and DEPTH/2 <= ceil(`blk_len_bytes`/4) < 3/4 of DEPTH, `wr_go` rises when the level reaches DEPTH/4.
- R4: With `cfg_start_now`=0 and ceil(`blk_len_bytes`/4) < DEPTH/2, `wr_go` rises only when the level equals the whole block in words (at least 1). Once high, `wr_go` stays high until the next `xfer_start`. It is always 0 during a read.
- R5: With `cfg_clr_on_read`=0, `stat_rd` does not clear `flag_ovf` or `flag_udf`. Only `xfer_start` clears them.
- R6: With `cfg_clr_on_read`=1, `stat_rd` clears both flags after one edge. If a new error event falls in the same cycle, its flag stays set.
- R7: With `cfg_sync_last`=0, a `card_blk_end` while `cmd_pending`=1 gives a one-cycle `cmd_issue` pulse on the following cycle.
- R8: With `cfg_sync_last`=1 and a latched nonzero `blk_count` N, `cmd_issue` pulses only for the N-th (and any later) `card_blk_end` after `xfer_start`.
- R9: With a latched `blk_count` of 0 (infinite transfer), every `card_blk_end` with `cmd_pending` gives `cmd_issue`, whatever `cfg_sync_last` is.
- R10: `launch_rise` equals `cfg_hs_edge`. 1 means the card-side outputs launch on the rising card clock edge, 0 means the falling edge.
- R11: During a write, `card_take` on an empty FIFO sets `flag_udf` and leaves the level at 0.
- R12: During a read, `card_give` on a full FIFO sets `flag_ovf` and drops the word, so the level and contents are unchanged.
- R13: The FIFO keeps words in first-in first-out order. `fifo_level` counts the stored words, `sys_wr_ready` is (write and not full), `sys_rd_valid` is (read and not empty), and `xfer_start` empties the FIFO and latches `xfer_write`, `blk_len_bytes` and `blk_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_now | input | 1 | Write begins with the first word |
| cfg_clr_on_read | input | 1 | Error flags clear on status read |
| cfg_hs_edge | input | 1 | High-speed launch edge select |
| cfg_sync_last | input | 1 | Hold a waiting command until the final block |
| blk_len_bytes | input | LEN_W | Block length in bytes |
| blk_count | input | CNT_W | Number of blocks, 0 means infinite |
| xfer_start | input | 1 | New transfer command; flushes FIFO and flags |
| xfer_write | input | 1 | Direction for the new transfer: 1 = toward card |
| sys_wr_valid | input | 1 | System offers a word |
| sys_wr_ready | output | 1 | FIFO accepts a system word |
| sys_wr_data | input | WIDTH | System write word |
| sys_rd_pop | input | 1 | System takes the head word |
| sys_rd_valid | output | 1 | Head word available to the system |
| sys_rd_data | output | WIDTH | Head word toward the system |
| stat_rd | input | 1 | Status read strobe |
| flag_ovf | output | 1 | Overflow flag |
| flag_udf | output | 1 | Underflow flag |
| fifo_level | output | $clog2(DEPTH+1) | Words stored |
| card_take | input | 1 | Card engine takes a word (write) |
| card_rd_data | output | WIDTH | Head word toward the card engine |
| card_give | input | 1 | Card engine delivers a word (read) |
| card_wr_data | input | WIDTH | Word from the card engine |
| card_blk_end | input | 1 | End of one data block |
| cmd_pending | input | 1 | A command is waiting to be issued |
| cmd_issue | output | 1 | One-cycle pulse: issue the waiting command now |
| wr_go | output | 1 | Write transfer toward the card may run |
| launch_rise | output | 1 | Card outputs launch on the rising edge |

## Verification
A status read and a new error event can fall in the same cycle. The first must clear a flag and the second must set it. The bench provokes this by starving the FIFO with `card_take` while it pulses `stat_rd` in clear-on-read mode, and it expects `flag_udf` to stay set on the next cycle. The random phase reaches the same collision often, and it also overlaps pushes and pops on a full or empty FIFO. A bench model judges every cycle, and in that model an event always wins over a clear.

// File: rtl/sdhost_xfer_ctl.sv
module sdhost_xfer_ctl #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_start_now,
  input  logic                         cfg_clr_on_read,
  input  logic                         cfg_hs_edge,
  input  logic                         cfg_sync_last,
  input  logic [LEN_W-1:0]             blk_len_bytes,
  input  logic [CNT_W-1:0]             blk_count,
  input  logic                         xfer_start,
  input  logic                         xfer_write,
  input  logic                         sys_wr_valid,
  output logic                         sys_wr_ready,
  input  logic [WIDTH-1:0]             sys_wr_data,
  input  logic                         sys_rd_pop,
  output logic                         sys_rd_valid,
  output logic [WIDTH-1:0]             sys_rd_data,
  input  logic                         stat_rd,
  output logic                         flag_ovf,
  output logic                         flag_udf,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_level,
  input  logic                         card_take,
  output logic [WIDTH-1:0]             card_rd_data,
  input  logic                         card_give,
  input  logic [WIDTH-1:0]             card_wr_data,
  input  logic                         card_blk_end,
  input  logic                         cmd_pending,
  output logic                         cmd_issue,
  output logic                         wr_go,
  output logic                         launch_rise
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int WW = LEN_W + 1;
  localparam logic [WW-1:0] T_Q3   = WW'(3*DEPTH/4);
  localparam logic [WW-1:0] T_HALF = WW'(DEPTH/2);
  localparam logic [WW-1:0] T_QTR  = WW'(DEPTH/4);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             dir_q, go_q, ovf_q, udf_q, issue_q;
  logic [WW-1:0]    words_q, thr;
  logic [CNT_W-1:0] nblk_q, done_q;

  wire full  = (cnt == CW'(DEPTH));
  wire empty = (cnt == '0);

  wire push_req = dir_q ? sys_wr_valid : card_give;
  wire pop_req  = dir_q ? card_take    : sys_rd_pop;
  wire push     = !xfer_start && push_req && !full;
  wire pop      = !xfer_start && pop_req && !empty;
  wire [WIDTH-1:0] push_data = dir_q ? sys_wr_data : card_wr_data;

  wire ovf_ev = !xfer_start && !dir_q && card_give && full;
  wire udf_ev = !xfer_start && dir_q && card_take && empty;
  wire flag_clr = stat_rd && cfg_clr_on_read;

  always_comb begin
    if (cfg_start_now)          thr = WW'(1);
    else if (words_q >= T_Q3)   thr = T_HALF;
    else if (words_q >= T_HALF) thr = T_QTR;
    else if (words_q == '0)     thr = WW'(1);
    else                        thr = words_q;
  end

  wire [WW-1:0] cnt_w = WW'(cnt);
  wire reached = dir_q && (cnt_w >= thr);

  wire [CNT_W:0] done_nx = {1'b0, done_q} + 1'b1;
  wire last_blk  = (nblk_q != '0) && (done_nx >= {1'b0, nblk_q});
  wire issue_now = !xfer_start && card_blk_end && cmd_pending &&
                   (!cfg_sync_last || nblk_q == '0 || last_blk);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      dir_q <= 1'b0; go_q <= 1'b0;
      ovf_q <= 1'b0; udf_q <= 1'b0; issue_q <= 1'b0;
      words_q <= '0; nblk_q <= '0; done_q <= '0;
    end else if (xfer_start) begin
      wp <= '0; rp <= '0; cnt <= '0;
      dir_q   <= xfer_write;
      go_q    <= 1'b0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      issue_q <= 1'b0;
      words_q <= (WW'(blk_len_bytes) + WW'(3)) >> 2;
      nblk_q  <= blk_count;
      done_q  <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt     <= cnt + CW'(push) - CW'(pop);
      go_q    <= go_q | reached;
      ovf_q   <= ovf_ev | (ovf_q & !flag_clr);
      udf_q   <= udf_ev | (udf_q & !flag_clr);
      issue_q <= issue_now;
      if (card_blk_end && done_q != '1) done_q <= done_q + 1'b1;
    end
  end

  assign sys_wr_ready = dir_q && !full;
  assign sys_rd_valid = !dir_q && !empty;
  assign sys_rd_data  = mem[rp];
  assign card_rd_data = mem[rp];
  assign fifo_level   = cnt;
  assign flag_ovf     = ovf_q;
  assign flag_udf     = udf_q;
  assign cmd_issue    = issue_q;
  assign wr_go        = dir_q && (go_q || reached);
  assign launch_rise  = cfg_hs_edge;

  // R13
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));

  // R12
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovf) |-> $past(card_give && !dir_q && full));

  // R12
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !dir_q && card_give && !sys_rd_pop && !xfer_start) |=> (fifo_level == CW'(DEPTH)));

  // R11
  udf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_udf) |-> $past(card_take && dir_q && empty));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_udf && !cfg_clr_on_read && !xfer_start) |=> flag_udf);

  // R7
  issue_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> $past(card_blk_end && cmd_pending));

  // R4
  go_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !xfer_start) |=> wr_go);
endmodule

// File: tb/sdhost_xfer_ctl_bench.sv
module sdhost_xfer_ctl_bench;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start_now = 0, cfg_clr_on_read = 0, cfg_hs_edge = 0, cfg_sync_last = 0;
  logic [11:0] blk_len_bytes = 12'd64;
  logic [15:0] blk_count = 16'd0;
  logic xfer_start = 0, xfer_write = 0, sys_wr_valid = 0, sys_rd_pop = 0, stat_rd = 0;
  logic card_take = 0, card_give = 0, card_blk_end = 0, cmd_pending = 0;
  logic [31:0] sys_wr_data = '0, card_wr_data = '0;
  logic sys_wr_ready, sys_rd_valid, flag_ovf, flag_udf, cmd_issue, wr_go, launch_rise;
  logic [31:0] sys_rd_data, card_rd_data;
  logic [4:0] fifo_level;

  sdhost_xfer_ctl u_sdhost_xfer_ctl (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  string cur = "R13";
  bit finished = 0;

  logic [31:0] mq[$];
  bit m_dir, m_goq, m_ovf, m_udf, m_issue;
  int m_words, m_nblk, m_done;

  function automatic int thr_of(int words, bit now);
    if (now) return 1;
    if (words >= 3*D/4) return D/2;
    if (words >= D/2) return D/4;
    return (words < 1) ? 1 : words;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s act=%0h exp=%0h @%0t", cur, tag, act, exp, $time);
    end
  endtask

  task automatic predict();
    int sz, thr;
    bit push, pop, ovfe, udfe, clr;
    if (xfer_start) begin
      mq.delete(); m_dir = xfer_write; m_goq = 0; m_ovf = 0; m_udf = 0; m_issue = 0;
      m_words = (int'(blk_len_bytes) + 3) / 4; m_nblk = int'(blk_count); m_done = 0;
      return;
    end
    sz = mq.size();
    thr = thr_of(m_words, cfg_start_now);
    m_issue = card_blk_end && cmd_pending &&
              (!cfg_sync_last || m_nblk == 0 || m_done + 1 >= m_nblk);
    if (card_blk_end && m_done != 16'hFFFF) m_done++;
    m_goq = m_goq | (m_dir && sz >= thr);
    push = (m_dir ? sys_wr_valid : card_give) && sz < D;
    pop  = (m_dir ? card_take : sys_rd_pop) && sz > 0;
    ovfe = !m_dir && card_give && sz == D;
    udfe = m_dir && card_take && sz == 0;
    clr  = stat_rd && cfg_clr_on_read;
    m_ovf = ovfe | (m_ovf & !clr);
    m_udf = udfe | (m_udf & !clr);
    if (pop) void'(mq.pop_front());
    if (push) mq.push_back(m_dir ? sys_wr_data : card_wr_data);
  endtask

  task automatic compare();
    int sz;
    sz = mq.size();
    chk("R13 level", fifo_level, sz);
    chk("R13 wr_ready", sys_wr_ready, m_dir && sz < D);
    chk("R13 rd_valid", sys_rd_valid, !m_dir && sz > 0);
    if (sz > 0) begin
      chk("R13 card_head", card_rd_data, mq[0]);
      chk("R13 sys_head", sys_rd_data, mq[0]);
    end
    chk("R12 ovf", flag_ovf, m_ovf);
    chk("R11 udf", flag_udf, m_udf);
    chk("R7 issue", cmd_issue, m_issue);
    chk("R4 wr_go", wr_go, m_dir && (m_goq || sz >= thr_of(m_words, cfg_start_now)));
    chk("R10 launch", launch_rise, cfg_hs_edge);
  endtask

  task automatic tick();
    predict();
    @(posedge clk);
    @(negedge clk);
    compare();
    xfer_start = 0; sys_wr_valid = 0; sys_rd_pop = 0; stat_rd = 0;
    card_take = 0; card_give = 0; card_blk_end = 0;
  endtask

  task automatic start(bit wr, int len, int nb);
    xfer_write = wr; blk_len_bytes = 12'(len); blk_count = 16'(nb); xfer_start = 1;
    tick();
  endtask

  task automatic thr_case(int len, bit now, int exp_thr);
    int pushes = 0;
    cfg_start_now = now;
    start(1, len, 1);
    while (!wr_go && pushes < D) begin
      sys_wr_valid = 1; sys_wr_data = $urandom; tick(); pushes++;
    end
    chk("threshold", pushes, exp_thr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D1C0DE));
    m_dir = 0; m_goq = 0; m_ovf = 0; m_udf = 0; m_issue = 0;
    m_words = 0; m_nblk = 0; m_done = 0;
    repeat (3) @(negedge clk);
    cur = "R13";
    compare();
    rst_n = 1;
    @(negedge clk);

    cur = "R10"; cfg_hs_edge = 1; tick(); cfg_hs_edge = 0; tick();

    cur = "R1"; thr_case(64, 1, 1);
    cur = "R2"; thr_case(64, 0, 8);
    cur = "R2"; thr_case(48, 0, 8);
    cur = "R3"; thr_case(44, 0, 4);
    cur = "R3"; thr_case(32, 0, 4);
    cur = "R4"; thr_case(20, 0, 5);
    cur = "R4"; thr_case(18, 0, 5);
    cur = "R4"; thr_case(4, 0, 1);

    cur = "R11"; cfg_clr_on_read = 0;
    start(1, 64, 1);
    card_take = 1; tick();
    chk("udf_set", flag_udf, 1);
    cur = "R5";
    stat_rd = 1; tick();
    chk("udf_held", flag_udf, 1);
    start(1, 64, 1);
    chk("udf_start_clr", flag_udf, 0);

    cur = "R6"; cfg_clr_on_read = 1;
    card_take = 1; tick();
    stat_rd = 1; tick();
    chk("udf_rd_clr", flag_udf, 0);
    card_take = 1; tick();
    stat_rd = 1; card_take = 1; tick();
    chk("udf_event_wins", flag_udf, 1);
    cfg_clr_on_read = 0;

    cur = "R12";
    start(0, 64, 1);
    for (int i = 0; i < D + 1; i++) begin
      card_give = 1; card_wr_data = 32'hA000_0000 + 32'(i); tick();
    end
    chk("ovf_set", flag_ovf, 1);
    chk("ovf_level", fifo_level, D);
    chk("ovf_head", sys_rd_data, 32'hA000_0000);
    cur = "R13";
    for (int i = 0; i < D; i++) begin sys_rd_pop = 1; tick(); end
    chk("drain_empty", fifo_level, 0);

    cur = "R7"; cfg_sync_last = 0; cmd_pending = 1;
    start(1, 64, 3);
    card_blk_end = 1; tick();
    chk("issue_first", cmd_issue, 1);
    tick();
    chk("issue_pulse", cmd_issue, 0);

    cur = "R8"; cfg_sync_last = 1;
    start(1, 64, 3);
    card_blk_end = 1; tick(); chk("b1", cmd_issue, 0);
    card_blk_end = 1; tick(); chk("b2", cmd_issue, 0);
    card_blk_end = 1; tick(); chk("b3", cmd_issue, 1);

    cur = "R9";
    start(1, 64, 0);
    card_blk_end = 1; tick(); chk("inf_issue", cmd_issue, 1);
    cmd_pending = 0;

    cur = "R13";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) == 0) begin
        xfer_write = 1'($urandom); blk_len_bytes = 12'($urandom_range(1, 80));
        blk_count = 16'($urandom_range(0, 4)); xfer_start = 1;
      end
      if ($urandom_range(0, 199) == 0) cfg_start_now = 1'($urandom);
      if ($urandom_range(0, 199) == 0) cfg_clr_on_read = 1'($urandom);
      if ($urandom_range(0, 199) == 0) cfg_sync_last = 1'($urandom);
      if ($urandom_range(0, 199) == 0) cfg_hs_edge = 1'($urandom);
      sys_wr_valid = ($urandom_range(0, 2) != 0);
      sys_wr_data = $urandom;
      sys_rd_pop = ($urandom_range(0, 2) == 0);
      card_take = ($urandom_range(0, 2) == 0);
      card_give = ($urandom_range(0, 2) != 0);
      card_wr_data = $urandom;
      stat_rd = ($urandom_range(0, 5) == 0);
      card_blk_end = ($urandom_range(0, 9) == 0);
      cmd_pending = 1'($urandom);
      tick();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule